// File: doc/BRIEF.md
# Flyby DMA Controller

This block moves a burst of 32-bit words between memory and a peripheral without ever holding the data itself. It has two faces that share one small register file.

A processor reaches the slave face with single-cycle accesses. Through it the processor loads a start address and a word count, picks a direction and optionally enables an interrupt. Setting the arm bit prepares a burst, but the burst only begins once the peripheral raises its request. The controller then asks the bus arbiter for ownership. Once ownership is granted it holds the bus locked and answers the peripheral with a grant. It drives the word address and the read/write qualifier for each beat while the peripheral places or takes the data on the shared data bus.

A burst ends when the count runs down to zero or when the peripheral withdraws its request, whichever comes first. The controller then sets a completion flag and, when enabled, an interrupt line. Programming errors are caught at arm time: a misaligned start address or a zero count sets an error flag, and no burst follows.

Top module: `flyby_dma`

## Requirements
- R1: A slave access is decoded only while `s_sel` is high, `s_addr[31:4]` equals `BASE[31:4]` (default `BASE` 0x400) and `s_addr[1:0]` is 0. `s_addr[3:2]` then picks the register: 0 start address, 1 word count, 2 control, 3 status.
- R2: `s_ack` is high in exactly the cycles holding a decoded access, combinationally in that same cycle. `s_rdata_en` is high only for decoded reads. `s_rdata` is 0 whenever `s_rdata_en` is low.
- R3: Reads return the full 32-bit start address and the full 32-bit count. Control reads as bit 0 direction (1 = read), bit 1 armed, bit 2 interrupt enable. Status reads as bit 0 done, bit 1 busy, bit 2 interrupt enable, bit 3 error. All other bits read 0, and writes to status have no effect.
- R4: Processor writes to every register are ignored while busy, and also in the cycle a burst starts.
- R5: An armed burst starts at the first clock edge where the peripheral request `p_req` is high. From the next cycle busy reads 1, the armed bit reads 0 and `m_req` is high. While unarmed, a high `p_req` starts nothing.
- R6: While waiting for `m_gnt`, only `m_req` is driven high. From the cycle after `m_gnt` is sampled, `m_req`, `m_lock`, `m_sel` and `p_gnt` are all high and `m_rnw` equals the direction bit. The first `m_addr` is the start address. `m_addr` and `m_rnw` are 0 whenever `m_sel` is low.
- R7: Each cycle with `m_sel` and `m_ack` high moves one word: the next `m_addr` is 4 higher and the count register drops by 1.
- R8: The burst ends on an acknowledged word while the count is 1, or in any cycle of the burst (waiting or moving) with `p_req` low. In the next cycle all bus and grant outputs are low, busy is 0 and done is 1.
- R9: `irq` is high exactly when done and interrupt enable are both set.
- R10: Writing control with bit 1 set clears done. If the start address is not a multiple of 4 or the count is 0, it sets error and leaves the block unarmed. Otherwise it clears error and arms.
- R11: Writing control with bit 1 clear disarms a pending burst and updates direction and interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_sel | input | 1 | Slave access valid |
| s_rnw | input | 1 | Slave access is a read |
| s_addr | input | 32 | Slave byte address |
| s_wdata | input | 32 | Slave write data |
| s_ack | output | 1 | Slave transfer acknowledge |
| s_rdata | output | 32 | Slave read data |
| s_rdata_en | output | 1 | Slave read data enable |
| m_req | output | 1 | Bus request to arbiter |
| m_lock | output | 1 | Bus lock during burst |
| m_gnt | input | 1 | Bus grant from arbiter |
| m_sel | output | 1 | Master address valid |
| m_rnw | output | 1 | Master direction (1 = memory read) |
| m_addr | output | 32 | Master word address |
| m_ack | input | 1 | Word transfer acknowledge from memory |
| p_req | input | 1 | Peripheral DMA request |
| p_gnt | output | 1 | Grant to peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
The bench aims at the edges of a burst.

- A peripheral request that falls while the controller still waits for the arbiter must end the burst with done set and no beat issued. A design that ignores the fall would hang in the wait, or would start driving addresses with no requester.
- An acknowledge on the final counted word must end the burst in that same cycle. A design that tests the count after decrementing would issue one beat too many.
- Processor writes in the start cycle and during the burst must leave the registers untouched. A design that lets them through would corrupt the count mid-burst.
- Arming with a misaligned address or a zero count must raise the error flag and start nothing. A careless design would arm anyway and drive a bad address.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_ARB  = 2'd1,
        ENG_MOVE = 2'd2
    } eng_state_e;

    typedef enum logic [1:0] {
        RSEL_START = 2'd0,
        RSEL_COUNT = 2'd1,
        RSEL_CTRL  = 2'd2,
        RSEL_STAT  = 2'd3
    } reg_sel_e;

    localparam int CB_DIR = 0;
    localparam int CB_GO  = 1;
    localparam int CB_IE  = 2;

    localparam int SB_DONE = 0;
    localparam int SB_BUSY = 1;
    localparam int SB_IE   = 2;
    localparam int SB_ERR  = 3;
endpackage

// File: rtl/fdma_decode.sv
module fdma_decode
    import fdma_pkg::*;
#(
    parameter int          AW   = 32,
    parameter int          DW   = 32,
    parameter logic [AW-1:0] BASE = 'h400
) (
    input  logic          s_sel,
    input  logic          s_rnw,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] start_word,
    input  logic [DW-1:0] count_word,
    input  logic [DW-1:0] ctrl_word,
    input  logic [DW-1:0] stat_word,
    output logic          s_ack,
    output logic          s_rdata_en,
    output logic [DW-1:0] s_rdata,
    output logic          wr_hit,
    output reg_sel_e      wr_sel
);
    localparam int OFFW = 4;

    logic     hit;
    reg_sel_e rsel;

    always_comb begin
        hit        = s_sel && (s_addr[AW-1:OFFW] == BASE[AW-1:OFFW]) && (s_addr[1:0] == 2'b00);
        rsel       = reg_sel_e'(s_addr[OFFW-1:2]);
        s_ack      = hit;
        s_rdata_en = hit && s_rnw;
        wr_hit     = hit && !s_rnw;
        wr_sel     = rsel;
        s_rdata    = '0;
        if (s_rdata_en) begin
            case (rsel)
                RSEL_START: s_rdata = start_word;
                RSEL_COUNT: s_rdata = count_word;
                RSEL_CTRL:  s_rdata = ctrl_word;
                default:    s_rdata = stat_word;
            endcase
        end
    end
endmodule

// File: rtl/fdma_regs.sv
module fdma_regs
    import fdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  reg_sel_e      wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_block,
    input  logic          eng_start,
    input  logic          eng_word,
    input  logic          eng_finish,
    output logic [AW-1:0] start_addr,
    output logic [DW-1:0] count,
    output logic          dir,
    output logic          go,
    output logic          ie,
    output logic          done,
    output logic          err
);
    typedef struct packed {
        logic [AW-1:0] sa;
        logic [DW-1:0] cnt;
        logic          dir;
        logic          go;
        logic          ie;
        logic          done;
        logic          err;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (eng_start)  regs_d.go   = 1'b0;
        if (eng_word)   regs_d.cnt  = regs_q.cnt - DW'(1);
        if (eng_finish) regs_d.done = 1'b1;
        if (wr_hit && !wr_block) begin
            case (wr_sel)
                RSEL_START: regs_d.sa  = AW'(wr_data);
                RSEL_COUNT: regs_d.cnt = wr_data;
                RSEL_CTRL: begin
                    regs_d.dir = wr_data[CB_DIR];
                    regs_d.ie  = wr_data[CB_IE];
                    if (wr_data[CB_GO]) begin
                        regs_d.done = 1'b0;
                        if ((regs_q.sa[1:0] != 2'b00) || (regs_q.cnt == '0)) begin
                            regs_d.err = 1'b1;
                            regs_d.go  = 1'b0;
                        end else begin
                            regs_d.err = 1'b0;
                            regs_d.go  = 1'b1;
                        end
                    end else begin
                        regs_d.go = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign start_addr = regs_q.sa;
    assign count      = regs_q.cnt;
    assign dir        = regs_q.dir;
    assign go         = regs_q.go;
    assign ie         = regs_q.ie;
    assign done       = regs_q.done;
    assign err        = regs_q.err;
endmodule

// File: rtl/fdma_engine.sv
module fdma_engine
    import fdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          dir,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] count,
    input  logic          p_req,
    input  logic          m_gnt,
    input  logic          m_ack,
    output logic          busy,
    output logic          eng_start,
    output logic          eng_word,
    output logic          eng_finish,
    output logic          m_req,
    output logic          m_lock,
    output logic          m_sel,
    output logic          m_rnw,
    output logic [AW-1:0] m_addr,
    output logic          p_gnt
);
    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        eng_state_e    st;
        logic [AW-1:0] ptr;
    } eng_t;

    eng_t eng_d, eng_q;
    logic moving;

    always_comb begin
        eng_d      = eng_q;
        eng_start  = 1'b0;
        eng_word   = 1'b0;
        eng_finish = 1'b0;
        case (eng_q.st)
            ENG_IDLE: begin
                if (go && p_req) begin
                    eng_start = 1'b1;
                    eng_d.st  = ENG_ARB;
                    eng_d.ptr = start_addr;
                end
            end
            ENG_ARB: begin
                if (!p_req) begin
                    eng_finish = 1'b1;
                    eng_d.st   = ENG_IDLE;
                end else if (m_gnt) begin
                    eng_d.st = ENG_MOVE;
                end
            end
            ENG_MOVE: begin
                if (m_ack) begin
                    eng_word  = 1'b1;
                    eng_d.ptr = eng_q.ptr + STEP;
                end
                if ((m_ack && (count == DW'(1))) || !p_req) begin
                    eng_finish = 1'b1;
                    eng_d.st   = ENG_IDLE;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ENG_IDLE, ptr: '0};
        else        eng_q <= eng_d;
    end

    always_comb begin
        moving = (eng_q.st == ENG_MOVE);
        busy   = (eng_q.st != ENG_IDLE);
        m_req  = busy;
        m_lock = moving;
        m_sel  = moving;
        p_gnt  = moving;
        m_rnw  = moving && dir;
        m_addr = moving ? eng_q.ptr : '0;
    end
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import fdma_pkg::*;
#(
    parameter int            AW   = 32,
    parameter int            DW   = 32,
    parameter logic [AW-1:0] BASE = 'h400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_sel,
    input  logic          s_rnw,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_wdata,
    output logic          s_ack,
    output logic [DW-1:0] s_rdata,
    output logic          s_rdata_en,
    output logic          m_req,
    output logic          m_lock,
    input  logic          m_gnt,
    output logic          m_sel,
    output logic          m_rnw,
    output logic [AW-1:0] m_addr,
    input  logic          m_ack,
    input  logic          p_req,
    output logic          p_gnt,
    output logic          irq
);
    logic          wr_hit;
    reg_sel_e      wr_sel;
    logic [AW-1:0] start_addr;
    logic [DW-1:0] count;
    logic          dir, go, ie, done, err, busy;
    logic          eng_start, eng_word, eng_finish;
    logic [DW-1:0] ctrl_word, stat_word;

    always_comb begin
        ctrl_word         = '0;
        ctrl_word[CB_DIR] = dir;
        ctrl_word[CB_GO]  = go;
        ctrl_word[CB_IE]  = ie;
        stat_word          = '0;
        stat_word[SB_DONE] = done;
        stat_word[SB_BUSY] = busy;
        stat_word[SB_IE]   = ie;
        stat_word[SB_ERR]  = err;
    end

    fdma_decode #(.AW(AW), .DW(DW), .BASE(BASE)) u_decode (
        .s_sel      (s_sel),
        .s_rnw      (s_rnw),
        .s_addr     (s_addr),
        .start_word (DW'(start_addr)),
        .count_word (count),
        .ctrl_word  (ctrl_word),
        .stat_word  (stat_word),
        .s_ack      (s_ack),
        .s_rdata_en (s_rdata_en),
        .s_rdata    (s_rdata),
        .wr_hit     (wr_hit),
        .wr_sel     (wr_sel)
    );

    fdma_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .wr_sel     (wr_sel),
        .wr_data    (s_wdata),
        .wr_block   (busy || eng_start),
        .eng_start  (eng_start),
        .eng_word   (eng_word),
        .eng_finish (eng_finish),
        .start_addr (start_addr),
        .count      (count),
        .dir        (dir),
        .go         (go),
        .ie         (ie),
        .done       (done),
        .err        (err)
    );

    fdma_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .dir        (dir),
        .start_addr (start_addr),
        .count      (count),
        .p_req      (p_req),
        .m_gnt      (m_gnt),
        .m_ack      (m_ack),
        .busy       (busy),
        .eng_start  (eng_start),
        .eng_word   (eng_word),
        .eng_finish (eng_finish),
        .m_req      (m_req),
        .m_lock     (m_lock),
        .m_sel      (m_sel),
        .m_rnw      (m_rnw),
        .m_addr     (m_addr),
        .p_gnt      (p_gnt)
    );

    assign irq = done && ie;
endmodule

// File: rtl/fdma_checker.sv
module fdma_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_sel,
    input logic          s_rnw,
    input logic          s_ack,
    input logic          s_rdata_en,
    input logic          m_req,
    input logic          m_lock,
    input logic          m_sel,
    input logic          m_ack,
    input logic [AW-1:0] m_addr,
    input logic          p_gnt,
    input logic          p_req,
    input logic          busy,
    input logic          done
);
    p_ack_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> s_sel);

    p_rden_is_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_rdata_en |-> (s_ack && s_rnw));

    p_start_needs_preq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_req) |-> $past(p_req));

    p_move_bundle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_sel |-> (m_req && m_lock && p_gnt && busy));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_sel && m_ack) |=> (!m_sel || (m_addr == $past(m_addr) + AW'(4))));

    p_done_after_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_req) |-> (done && !busy));
endmodule

bind flyby_dma fdma_checker #(.AW(AW)) u_fdma_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_sel      (s_sel),
    .s_rnw      (s_rnw),
    .s_ack      (s_ack),
    .s_rdata_en (s_rdata_en),
    .m_req      (m_req),
    .m_lock     (m_lock),
    .m_sel      (m_sel),
    .m_ack      (m_ack),
    .m_addr     (m_addr),
    .p_gnt      (p_gnt),
    .p_req      (p_req),
    .busy       (busy),
    .done       (done)
);

// File: tb/flyby_dma_bench.sv
module flyby_dma_bench;
    localparam logic [31:0] BASE = 32'h400;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        s_sel = 1'b0, s_rnw = 1'b0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        m_gnt = 1'b0, m_ack = 1'b0, p_req = 1'b0;
    logic        s_ack, s_rdata_en, m_req, m_lock, m_sel, m_rnw, p_gnt, irq;
    logic [31:0] s_rdata, m_addr;

    flyby_dma u_flyby_dma (
        .clk(clk), .rst_n(rst_n), .s_sel(s_sel), .s_rnw(s_rnw), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_ack(s_ack), .s_rdata(s_rdata), .s_rdata_en(s_rdata_en),
        .m_req(m_req), .m_lock(m_lock), .m_gnt(m_gnt), .m_sel(m_sel), .m_rnw(m_rnw),
        .m_addr(m_addr), .m_ack(m_ack), .p_req(p_req), .p_gnt(p_gnt), .irq(irq)
    );

    int vectors = 0, misses = 0;
    bit finished = 1'b0;

    // behavioural reference: 0 idle, 1 waiting for bus, 2 moving words
    int          mst;
    logic [31:0] sa, cnt, ptr;
    bit          dir, go, ie, done, err;
    bit          auto_resp = 1'b1;
    int          gnt_pct = 50, ack_pct = 70;

    function automatic logic [31:0] mreg(input logic [1:0] i);
        case (i)
            2'd0: return sa;
            2'd1: return cnt;
            2'd2: return {29'b0, ie, go, dir};
            default: return {28'b0, err, ie, (mst != 0), done};
        endcase
    endfunction

    function automatic bit hit_now();
        return s_sel && (s_addr[31:4] == BASE[31:4]) && (s_addr[1:0] == 2'b00);
    endfunction

    task automatic chk(input string what, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit h = hit_now();
        bit mv = (mst == 2);
        chk("s_ack", "R2", 32'(s_ack), 32'(h));
        chk("s_rdata_en", "R2", 32'(s_rdata_en), 32'(h && s_rnw));
        chk("s_rdata", "R3", s_rdata, (h && s_rnw) ? mreg(s_addr[3:2]) : 32'h0);
        chk("m_req", "R5", 32'(m_req), 32'(mst != 0));
        chk("m_lock", "R6", 32'(m_lock), 32'(mv));
        chk("m_sel", "R6", 32'(m_sel), 32'(mv));
        chk("p_gnt", "R6", 32'(p_gnt), 32'(mv));
        chk("m_rnw", "R6", 32'(m_rnw), 32'(mv && dir));
        chk("m_addr", "R7", m_addr, mv ? ptr : 32'h0);
        chk("irq", "R9", 32'(irq), 32'(done && ie));
    endtask

    task automatic model_update();
        int          o_mst = mst;
        logic [31:0] o_cnt = cnt;
        bit          start = (o_mst == 0) && go && p_req;
        bit          wr = hit_now() && !s_rnw && (o_mst == 0) && !start;
        if (start) begin
            mst = 1; ptr = sa; go = 0;
        end else if (o_mst == 1) begin
            if (!p_req) begin mst = 0; done = 1; end
            else if (m_gnt) mst = 2;
        end else if (o_mst == 2) begin
            if (m_ack) begin ptr = ptr + 4; cnt = o_cnt - 1; end
            if ((m_ack && o_cnt == 1) || !p_req) begin mst = 0; done = 1; end
        end
        if (wr) begin
            case (s_addr[3:2])
                2'd0: sa = s_wdata;
                2'd1: cnt = s_wdata;
                2'd2: begin
                    dir = s_wdata[0];
                    ie  = s_wdata[2];
                    if (s_wdata[1]) begin
                        done = 0;
                        if (sa[1:0] != 0 || cnt == 0) begin err = 1; go = 0; end
                        else begin err = 0; go = 1; end
                    end else go = 0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        if (auto_resp) begin
            m_gnt = (mst == 1) && ($urandom_range(99) < gnt_pct);
            m_ack = (mst == 2) && ($urandom_range(99) < ack_pct);
        end
        #2 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic cpu_wr(input logic [31:0] a, input logic [31:0] d);
        s_sel = 1; s_rnw = 0; s_addr = a; s_wdata = d;
        tick();
        s_sel = 0; s_wdata = '0;
    endtask

    task automatic cpu_rd(input logic [31:0] a);
        s_sel = 1; s_rnw = 1; s_addr = a;
        tick();
        s_sel = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && mst != 0; i++) tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            misses++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        mst = 0; sa = 0; cnt = 0; ptr = 0; dir = 0; go = 0; ie = 0; done = 0; err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state of all outputs and registers (R3)
        idle(2);
        for (int i = 0; i < 4; i++) cpu_rd(BASE + 32'(4 * i));

        // R1: unselected, off-base and misaligned accesses are not acknowledged
        s_sel = 0; s_rnw = 0; s_addr = BASE; s_wdata = 32'h1234; tick();
        cpu_wr(32'h500, 32'h5);
        cpu_wr(BASE + 2, 32'h7);
        cpu_rd(BASE);

        // R5/R6/R7/R8/R9: read-direction burst of 3 words with interrupt
        cpu_wr(BASE + 0, 32'h8000);
        cpu_wr(BASE + 4, 32'd3);
        cpu_wr(BASE + 8, 32'h7);
        cpu_rd(BASE + 8);
        idle(3);                       // armed, no request: R5 nothing starts
        p_req = 1;
        tick();
        cpu_wr(BASE + 4, 32'd99);      // R4 write while busy ignored
        wait_idle();
        cpu_rd(BASE + 4);              // R7 count ran to zero
        cpu_rd(BASE + 12);             // R8 done, R9 irq
        p_req = 0;

        // R4: write landing in the start cycle is ignored
        cpu_wr(BASE + 4, 32'd2);
        cpu_wr(BASE + 8, 32'h2);       // R10 clears done, arms, write direction
        p_req = 1;
        cpu_wr(BASE + 0, 32'h9000);
        wait_idle();
        cpu_rd(BASE + 0);
        p_req = 0;

        // R8: peripheral drops request mid-burst
        cpu_wr(BASE + 4, 32'd5);
        cpu_wr(BASE + 8, 32'h6);
        p_req = 1; gnt_pct = 100; ack_pct = 100;
        idle(4);
        p_req = 0;
        idle(2);
        cpu_rd(BASE + 4);
        cpu_rd(BASE + 12);

        // R8: request drops while waiting for the bus
        auto_resp = 0; m_gnt = 0; m_ack = 0;
        cpu_wr(BASE + 8, 32'h2);
        p_req = 1; tick(); tick();
        p_req = 0; tick(); tick();
        cpu_rd(BASE + 12);
        auto_resp = 1; gnt_pct = 50; ack_pct = 70;

        // R10: misaligned address and zero count raise error
        cpu_wr(BASE + 0, 32'h8002);
        cpu_wr(BASE + 8, 32'h2);
        p_req = 1; idle(3);
        cpu_rd(BASE + 12);
        p_req = 0;
        cpu_wr(BASE + 0, 32'h8000);
        cpu_wr(BASE + 4, 32'd0);
        cpu_wr(BASE + 8, 32'h2);
        cpu_rd(BASE + 12);

        // R11: disarm before request
        cpu_wr(BASE + 4, 32'd2);
        cpu_wr(BASE + 8, 32'h2);
        cpu_wr(BASE + 8, 32'h1);
        p_req = 1; idle(3);
        cpu_rd(BASE + 8);
        p_req = 0;
        cpu_wr(BASE + 12, 32'hF);      // R3 status write has no effect
        cpu_rd(BASE + 12);

        // mixed random traffic against the reference model
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(99);
            if ($urandom_range(99) < 8) p_req = ~p_req;
            if (r < 30) begin
                logic [1:0]  idx = 2'($urandom_range(3));
                logic [31:0] a = BASE + 32'(4 * idx);
                logic [31:0] d = $urandom;
                int          k = $urandom_range(9);
                if (k == 0) a = BASE + 32'h10;
                else if (k == 1) a = a | 32'h1;
                if (idx == 2'd0) d = 32'h8000 + 32'(4 * $urandom_range(63)) + ((k == 2) ? 32'h2 : 32'h0);
                if (idx == 2'd1) d = 32'($urandom_range(6));
                s_sel = 1; s_rnw = $urandom_range(1) == 1; s_addr = a; s_wdata = d;
                tick();
                s_sel = 0;
            end else begin
                tick();
            end
        end
        p_req = 0;
        wait_idle();
        idle(2);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule